// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of several software contexts, called localities, may use a shared secure-device register interface. Only one locality can own the interface at any time. Each locality has its own byte-wide access register. A host reads and writes these registers over a simple single-cycle port. The upper address bits select which locality's window is addressed.

A locality asks for the interface by writing its request-use bit. It then reads its access register until the active and valid bits are both set. It gives the interface up by writing the active bit. Requests that arrive while another locality owns the interface are held as pending. When the owner gives up, the pending requester with the highest number is granted on the same clock edge. The block also drives the current owner's number, an ownership-valid flag, and a one-cycle pulse on every change of owner, for a neighbouring interrupt block.

Top module: `locality_arbiter`

## Requirements
- R1: Locality l's access register sits at address l<<12 with the low 12 address bits zero, for l = 0 to 4. Reads anywhere else (windows 5 to 7, or a nonzero offset) return 0x00, and writes there change nothing.
- R2: A read of a locality's access register returns 0x80 (bit 7, valid), plus 0x20 (bit 5) if that locality is the owner, plus 0x04 (bit 2) if any other locality has a pending request, plus 0x02 (bit 1) if that locality's own request is pending. All other bits read 0.
- R3: When no locality is active, a write with bit 1 set grants that locality at the next clock edge. For example, locality 2 then reads 0xA0.
- R4: When the owner writes a byte with bit 5 set, ownership passes at that clock edge to the highest-numbered locality with a pending request.
- R5: When the owner gives up and no request is pending, no locality is active and active_valid reads 0.
- R6: A write with bit 5 set from a locality that is not the owner is ignored.
- R7: A write with bit 1 set from the current owner has no effect: no pending bit is set and no change event is raised.
- R8: loc_change is high for exactly one cycle after each clock edge at which the owner changes. This includes a change to no owner.
- R9: After reset, no locality is active, no request is pending, and loc_change is 0.
- R10: A request-use write from a non-owner while another locality owns the interface is held as pending until that locality is granted.
- R11: active_valid is 1 exactly when a locality owns the interface, and active_loc then gives its number (0 to 4). active_loc is 0 when no locality owns the interface.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 15 | Register address; bits 14:12 select the locality window |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| active_loc | output | 3 | Number of the owning locality |
| active_valid | output | 1 | A locality owns the interface |
| loc_change | output | 1 | One-cycle pulse after each change of owner |

## Verification
The bench builds the block with its defaults: five localities and a 12-bit window offset, which gives a 3-bit window field. Three window codes (5 to 7) are therefore decoded but unused, so the bench can check that out-of-range accesses are ignored. Five localities also allow up to four requests to be pending behind one owner. This exercises the highest-number pick over a real set of candidates. Alongside the directed sequences, random traffic is compared every cycle against a queue-and-integer model. This traffic includes combined request and relinquish bytes and writes to nonzero offsets.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int unsigned BIT_VALID  = 7;
  localparam int unsigned BIT_ACTIVE = 5;
  localparam int unsigned BIT_OTHERS = 2;
  localparam int unsigned BIT_REQ    = 1;

  // one-hot of the highest set bit, zero when none
  function automatic logic [7:0] highest_oh(input logic [7:0] v);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 8; i++)
      if (v[i]) r = 8'(1) << i;
    return r;
  endfunction

  function automatic logic [2:0] oh_to_idx(input logic [7:0] oh);
    logic [2:0] r;
    r = '0;
    for (int i = 0; i < 8; i++)
      if (oh[i]) r = 3'(i);
    return r;
  endfunction

  function automatic logic [7:0] pack_access(input logic is_owner,
                                             input logic others_wait,
                                             input logic own_wait);
    logic [7:0] r;
    r = '0;
    r[BIT_VALID]  = 1'b1;
    r[BIT_ACTIVE] = is_owner;
    r[BIT_OTHERS] = others_wait;
    r[BIT_REQ]    = own_wait;
    return r;
  endfunction
endpackage

// File: rtl/loc_decode.sv
module loc_decode #(
  parameter int NUM_LOC   = 5,
  parameter int WIN_SHIFT = 12,
  parameter int ADDR_W    = 15
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  output logic               hit,
  output logic [NUM_LOC-1:0] sel_oh,
  output logic [NUM_LOC-1:0] wr_oh
);
  localparam int SEL_W = ADDR_W - WIN_SHIFT;

  logic [SEL_W-1:0] win;
  assign win = addr[ADDR_W-1:WIN_SHIFT];
  assign hit = (addr[WIN_SHIFT-1:0] == '0) && (int'(win) < NUM_LOC);

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_sel
    assign sel_oh[g] = hit && (win == SEL_W'(g));
    assign wr_oh[g]  = sel_oh[g] && wr;
  end
endmodule

// File: rtl/loc_grant.sv
module loc_grant
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LOC-1:0] wr_oh,
  input  logic               want_use,
  input  logic               give_up,
  output logic [NUM_LOC-1:0] owner_q,
  output logic [NUM_LOC-1:0] pend_q,
  output logic               loc_change
);
  logic               rel_hit;
  logic [NUM_LOC-1:0] new_req, req_all, pick, owner_d, pend_d;
  logic [7:0]         pick8;

  always_comb begin
    rel_hit = (|(wr_oh & owner_q)) && give_up;
    new_req = want_use ? (wr_oh & ~owner_q) : '0;
    req_all = pend_q | new_req;
    pick8   = highest_oh(8'(req_all));
    pick    = pick8[NUM_LOC-1:0];
    if (rel_hit || owner_q == '0) owner_d = pick;
    else                          owner_d = owner_q;
    pend_d  = req_all & ~owner_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q    <= '0;
      pend_q     <= '0;
      loc_change <= 1'b0;
    end else begin
      owner_q    <= owner_d;
      pend_q     <= pend_d;
      loc_change <= (owner_d != owner_q);
    end
  end

  // R11
  owner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner_q));
  // R10
  pend_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & owner_q) == '0);
  // R6
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|owner_q) && !rel_hit) |=> $stable(owner_q));
  // R3
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == '0 && (|req_all)) |=> (|owner_q));
  // R4
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_hit && (|pend_q)) |=> (|owner_q));
  // R5
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_hit && req_all == '0) |=> (owner_q == '0));
  // R8
  change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != $past(owner_q)) |-> loc_change);
endmodule

// File: rtl/loc_status.sv
module loc_status
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic               hit,
  input  logic [NUM_LOC-1:0] sel_oh,
  input  logic [NUM_LOC-1:0] owner_q,
  input  logic [NUM_LOC-1:0] pend_q,
  output logic [7:0]         rdata
);
  always_comb begin
    if (hit)
      rdata = pack_access(|(owner_q & sel_oh),
                          |(pend_q & ~sel_oh),
                          |(pend_q & sel_oh));
    else
      rdata = '0;
  end
endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC   = 5,
  parameter int WIN_SHIFT = 12,
  parameter int ADDR_W    = WIN_SHIFT + 3,
  parameter int LOC_W     = $clog2(NUM_LOC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [LOC_W-1:0]  active_loc,
  output logic              active_valid,
  output logic              loc_change
);
  logic               hit;
  logic [NUM_LOC-1:0] sel_oh, wr_oh, owner_q, pend_q;
  logic [2:0]         idx3;

  loc_decode #(.NUM_LOC(NUM_LOC), .WIN_SHIFT(WIN_SHIFT), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .hit(hit), .sel_oh(sel_oh), .wr_oh(wr_oh));

  loc_grant #(.NUM_LOC(NUM_LOC)) u_grant (
    .clk(clk), .rst_n(rst_n), .wr_oh(wr_oh),
    .want_use(bus_wdata[BIT_REQ]), .give_up(bus_wdata[BIT_ACTIVE]),
    .owner_q(owner_q), .pend_q(pend_q), .loc_change(loc_change));

  loc_status #(.NUM_LOC(NUM_LOC)) u_stat (
    .hit(hit), .sel_oh(sel_oh), .owner_q(owner_q), .pend_q(pend_q),
    .rdata(bus_rdata));

  assign idx3         = oh_to_idx(8'(owner_q));
  assign active_loc   = idx3[LOC_W-1:0];
  assign active_valid = |owner_q;
endmodule

// File: tb/locality_arbiter_bench.sv
module locality_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [2:0]  active_loc;
  logic        active_valid, loc_change;

  locality_arbiter u_locality_arbiter (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .active_loc(active_loc),
    .active_valid(active_valid), .loc_change(loc_change));

  always #4 clk = ~clk;

  int    vectors = 0;
  int    fails = 0;
  string cur_tag = "R9";

  // behavioural model: owner as integer (-1 none), waiting list as a queue
  int ref_owner = -1;
  int ref_wait[$];
  bit ref_chg = 0;

  function automatic bit is_waiting(int l);
    foreach (ref_wait[i]) if (ref_wait[i] == l) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_owner = -1; ref_wait.delete(); ref_chg = 0;
    end else begin
      int win, prev, best, bi;
      bit acc;
      win  = int'(bus_addr[14:12]);
      acc  = bus_wr && bus_addr[11:0] == 0 && win < 5;
      prev = ref_owner;
      if (acc && bus_wdata[1] && win != ref_owner && !is_waiting(win))
        ref_wait.push_back(win);
      if ((acc && bus_wdata[5] && win == ref_owner) || ref_owner < 0) begin
        best = -1; bi = -1;
        foreach (ref_wait[i]) if (ref_wait[i] > best) begin best = ref_wait[i]; bi = i; end
        ref_owner = best;
        if (bi >= 0) ref_wait.delete(bi);
      end
      ref_chg = (ref_owner != prev);
    end
  end

  function automatic logic [7:0] exp_read(logic [14:0] a);
    int w;
    logic [7:0] r;
    w = int'(a[14:12]);
    if (a[11:0] != 0 || w >= 5) return 8'h00;
    r = 8'h80;
    if (ref_owner == w) r |= 8'h20;
    foreach (ref_wait[i]) begin
      if (ref_wait[i] == w) r |= 8'h02;
      else r |= 8'h04;
    end
    return r;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_model();
    chk(cur_tag, "rdata(R2)", bus_rdata, exp_read(bus_addr));
    chk(cur_tag, "valid(R11)", active_valid, ref_owner >= 0);
    chk(cur_tag, "loc(R11)", active_loc, ref_owner >= 0 ? ref_owner : 0);
    chk(cur_tag, "change(R8)", loc_change, ref_chg);
  endtask

  task automatic drive(int win, int off, bit w, logic [7:0] d, string tag);
    @(negedge clk);
    compare_model();
    bus_addr  = 15'((win << 12) | off);
    bus_wr    = w;
    bus_wdata = d;
    cur_tag   = tag;
  endtask

  task automatic expect_now(logic [7:0] rd, bit v, int l, bit c, string tag);
    #1;
    chk(tag, "rdata", bus_rdata, rd);
    chk(tag, "valid", active_valid, v);
    chk(tag, "loc", active_loc, l);
    chk(tag, "change", loc_change, c);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) drive(0, 0, 0, 8'h00, "R9");
    @(negedge clk); rst_n = 1'b1;
    // R9 reset state
    drive(0, 0, 0, 8'h00, "R9");  expect_now(8'h80, 0, 0, 0, "R9");
    // R3 idle grant
    drive(2, 0, 1, 8'h02, "R3");
    drive(2, 0, 0, 8'h00, "R3");  expect_now(8'hA0, 1, 2, 1, "R3");
    // R7 repeated request from owner
    drive(2, 0, 1, 8'h02, "R7");
    drive(2, 0, 0, 8'h00, "R7");  expect_now(8'hA0, 1, 2, 0, "R7");
    // R10 pending while busy
    drive(4, 0, 1, 8'h02, "R10");
    drive(2, 0, 0, 8'h00, "R10"); expect_now(8'hA4, 1, 2, 0, "R10");
    drive(4, 0, 0, 8'h00, "R10"); expect_now(8'h82, 1, 2, 0, "R10");
    // R6 relinquish from non-owner
    drive(4, 0, 1, 8'h20, "R6");
    drive(2, 0, 0, 8'h00, "R6");  expect_now(8'hA4, 1, 2, 0, "R6");
    drive(1, 0, 1, 8'h02, "R10");
    // R4 handover to highest pending
    drive(2, 0, 1, 8'h20, "R4");
    drive(4, 0, 0, 8'h00, "R4");  expect_now(8'hA4, 1, 4, 1, "R4");
    drive(4, 0, 1, 8'h20, "R4");
    drive(1, 0, 0, 8'h00, "R4");  expect_now(8'hA0, 1, 1, 1, "R4");
    // R5 release with nothing pending
    drive(1, 0, 1, 8'h20, "R5");
    drive(1, 0, 0, 8'h00, "R5");  expect_now(8'h80, 0, 0, 1, "R5");
    // R1 out-of-range window and nonzero offset
    drive(5, 0, 1, 8'h02, "R1");
    drive(5, 0, 0, 8'h00, "R1");  expect_now(8'h00, 0, 0, 0, "R1");
    drive(3, 4, 1, 8'h02, "R1");
    drive(3, 4, 0, 8'h00, "R1");  expect_now(8'h00, 0, 0, 0, "R1");
    drive(3, 0, 0, 8'h00, "R1");  expect_now(8'h80, 0, 0, 0, "R1");
    // random traffic against the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1: d = 8'h02;
        3'd2, 3'd3: d = 8'h20;
        3'd4:       d = 8'h22;
        3'd5:       d = 8'h80;
        default:    d = 8'h00;
      endcase
      drive(int'(lfsr[6:4]), lfsr[9:7] == 0 ? 4 : 0, lfsr[11], d, "R2");
    end
    drive(0, 0, 0, 8'h00, "R2");
    finish_run();
  end
endmodule